// File: doc/BRIEF.md
# BCD calendar time counter

This block keeps wall-clock time and date as packed BCD bytes: seconds, minutes, hours (24-hour form), day of month, weekday, month and a two-digit year. A century flag sits in the top bit of the month byte. A prescaler counts pulses of an external enable derived from a 32.768 kHz source. Each full prescaler period advances the seconds, and carries ripple up through the date with month lengths and leap years taken into account.

Software uses a byte-wide register port. Writes are synchronous and reads are combinational. A stop bit in the control register freezes the prescaler and the whole counter chain, so a new time can be loaded byte by byte without a carry landing in the middle of the update. Any write made while stopped also clears the prescaler, so counting restarts one full second after release. A validity flag in the top bit of the seconds byte is set by a power-fail input. It marks the stored time as untrustworthy until software rewrites the seconds.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset, the bytes read back as: seconds 0x80 (flag set, 00 s), minutes 0x00, hours 0x00, day 0x01, weekday 0x00, month 0x01 (century 0), year 0x00, control 0x00.
- R2: Register map: 0x0 control (bit 5 = stop, other bits read 0), 0x2 seconds (bits 6:0), 0x3 minutes (bits 6:0), 0x4 hours (bits 5:0), 0x5 day (bits 5:0), 0x6 weekday (bits 2:0), 0x7 month (bits 4:0, bit 7 = century), 0x8 year (bits 7:0). Unused bits and unmapped addresses read 0, and write data outside a field is dropped.
- R3: While running, the seconds value advances by one BCD step on every PRESCALE_DIV-th cycle in which ref_en is high, and at no other time.
- R4: Seconds wrap 59→00 and carry into minutes. Minutes wrap 59→00 and carry into hours. Hours wrap 23→00 and carry into day and weekday. Each field steps in BCD (x9 → (x+1)0).
- R5: Weekday counts 0..6 (0 = Sunday) and wraps 6→0 on a day carry.
- R6: Day wraps to 01 after day 31 in months 01, 03, 05, 07, 08, 10 and 12, and after day 30 in months 04, 06, 09 and 11. The wrap carries into the month.
- R7: In month 02 the day wraps after 29 when the BCD year is a multiple of 4, and after 28 otherwise.
- R8: Month wraps 12→01 and carries into the year. Year wraps 99→00 and inverts the century bit. A write to the month byte loads the century bit from bit 7.
- R9: While the stop bit is 1, neither the prescaler nor any time field changes except through a register write.
- R10: A write of any register while the stop bit is 1 resets the prescaler, so the first seconds step after release needs a full PRESCALE_DIV enabled cycles.
- R11: The validity flag (seconds bit 7) is set one cycle after pwr_fail is high. Otherwise it changes only when the seconds byte is written, taking bit 7 of the write data. pwr_fail wins over a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_en | input | 1 | One-cycle enable pulses from the 32.768 kHz domain |
| pwr_fail | input | 1 | Power-fail indication; sets the validity flag |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Combinational read data |

## Verification
The range and BCD-digit checks assume that software writes only legal BCD values within each field's range. They also assume that no time byte is written while the chain is running. The stimulus loads every time byte only between a stop and a release of the control register, and every value it loads is a legal calendar value. The freeze and wrap checks assume that pwr_fail touches only the flag. The bench pulses it only while time is static and then rewrites the seconds byte.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
   localparam int BYTE_W   = 8;
   localparam int STOP_POS = 5;
   localparam int FLAG_POS = 7;

   typedef enum logic [3:0] {
      RA_CTRL = 4'h0,
      RA_SEC  = 4'h2,
      RA_MIN  = 4'h3,
      RA_HOUR = 4'h4,
      RA_DAY  = 4'h5,
      RA_WDAY = 4'h6,
      RA_MON  = 4'h7,
      RA_YEAR = 4'h8
   } reg_addr_e;

   // one BCD step of a two-digit value
   function automatic logic [7:0] bcd_step(input logic [7:0] v);
      if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
      else                return {v[7:4], v[3:0] + 4'd1};
   endfunction

   // BCD year divisible by four
   function automatic logic leap_year(input logic [7:0] y);
      if (y[4] == 1'b0) return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
      else              return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
   endfunction

   // last day of a month, in BCD
   function automatic logic [7:0] last_day(input logic [4:0] m, input logic [7:0] y);
      case (m)
         5'h02:                      return leap_year(y) ? 8'h29 : 8'h28;
         5'h04, 5'h06, 5'h09, 5'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
   parameter int unsigned DIV = 32768
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic cnt_en,
   output logic tick
);
   localparam int  CW   = (DIV > 1) ? $clog2(DIV) : 1;
   localparam bit  POW2 = ((DIV & (DIV - 1)) == 0);

   logic [CW-1:0] cnt_q;

   if (DIV < 2) begin : g_bad_div
      $error("rtc_prescaler: DIV must be at least 2");
   end

   if (POW2) begin : g_pow2
      // natural wrap of the counter marks the period
      assign tick = cnt_en && (&cnt_q);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      cnt_q <= '0;
         else if (clr)    cnt_q <= '0;
         else if (cnt_en) cnt_q <= cnt_q + 1'b1;
      end
   end else begin : g_cmp
      assign tick = cnt_en && (cnt_q == CW'(DIV - 1));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      cnt_q <= '0;
         else if (clr)    cnt_q <= '0;
         else if (tick)   cnt_q <= '0;
         else if (cnt_en) cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field
   import rtc_cal_pkg::*;
#(
   parameter int unsigned W       = 7,
   parameter int unsigned FIRST_V = 0,
   parameter int unsigned RST_V   = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         step,
   input  logic [W-1:0] last_val,
   output logic [W-1:0] q,
   output logic         carry
);
   if (W < 3 || W > BYTE_W) begin : g_bad_w
      $error("rtc_bcd_field: W out of range");
   end

   logic [7:0] ext;
   assign ext   = 8'(q);
   assign carry = step && (q == last_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= W'(RST_V);
      else if (load)  q <= load_val;
      else if (carry) q <= W'(FIRST_V);
      else if (step)  q <= W'(bcd_step(ext));
   end
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
   import rtc_cal_pkg::*;
#(
   parameter int unsigned PRESCALE_DIV = 32768,
   parameter int unsigned ADDR_W       = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_en,
   input  logic              pwr_fail,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_data
);
   if (ADDR_W < 4) begin : g_bad_addr
      $error("rtc_calendar_core: ADDR_W must be at least 4");
   end

   logic stop_q, vl_q, cent_q;
   logic sec_tick;
   logic [6:0] sec_q, min_q;
   logic [5:0] hour_q, day_q;
   logic [2:0] wday_q;
   logic [4:0] mon_q;
   logic [7:0] year_q;
   logic sec_c, min_c, hour_c, day_c, wday_c, mon_c, year_c;
   logic [7:0] dlast;

   function automatic logic hit(input logic [ADDR_W-1:0] a, input reg_addr_e r);
      return a == ADDR_W'(r);
   endfunction

   logic w_ctrl, w_sec, w_min, w_hour, w_day, w_wday, w_mon, w_year;
   assign w_ctrl = wr_en && hit(wr_addr, RA_CTRL);
   assign w_sec  = wr_en && hit(wr_addr, RA_SEC);
   assign w_min  = wr_en && hit(wr_addr, RA_MIN);
   assign w_hour = wr_en && hit(wr_addr, RA_HOUR);
   assign w_day  = wr_en && hit(wr_addr, RA_DAY);
   assign w_wday = wr_en && hit(wr_addr, RA_WDAY);
   assign w_mon  = wr_en && hit(wr_addr, RA_MON);
   assign w_year = wr_en && hit(wr_addr, RA_YEAR);

   rtc_prescaler #(.DIV(PRESCALE_DIV)) u_presc (
      .clk(clk), .rst_n(rst_n),
      .clr(wr_en && stop_q),
      .cnt_en(ref_en && !stop_q),
      .tick(sec_tick)
   );

   assign dlast = last_day(mon_q, year_q);

   rtc_bcd_field #(.W(7), .FIRST_V(0), .RST_V(0)) u_sec (
      .clk(clk), .rst_n(rst_n), .load(w_sec), .load_val(wr_data[6:0]),
      .step(sec_tick), .last_val(7'h59), .q(sec_q), .carry(sec_c));

   rtc_bcd_field #(.W(7), .FIRST_V(0), .RST_V(0)) u_min (
      .clk(clk), .rst_n(rst_n), .load(w_min), .load_val(wr_data[6:0]),
      .step(sec_c), .last_val(7'h59), .q(min_q), .carry(min_c));

   rtc_bcd_field #(.W(6), .FIRST_V(0), .RST_V(0)) u_hour (
      .clk(clk), .rst_n(rst_n), .load(w_hour), .load_val(wr_data[5:0]),
      .step(min_c), .last_val(6'h23), .q(hour_q), .carry(hour_c));

   rtc_bcd_field #(.W(6), .FIRST_V(1), .RST_V(1)) u_day (
      .clk(clk), .rst_n(rst_n), .load(w_day), .load_val(wr_data[5:0]),
      .step(hour_c), .last_val(dlast[5:0]), .q(day_q), .carry(day_c));

   rtc_bcd_field #(.W(3), .FIRST_V(0), .RST_V(0)) u_wday (
      .clk(clk), .rst_n(rst_n), .load(w_wday), .load_val(wr_data[2:0]),
      .step(hour_c), .last_val(3'd6), .q(wday_q), .carry(wday_c));

   rtc_bcd_field #(.W(5), .FIRST_V(1), .RST_V(1)) u_mon (
      .clk(clk), .rst_n(rst_n), .load(w_mon), .load_val(wr_data[4:0]),
      .step(day_c), .last_val(5'h12), .q(mon_q), .carry(mon_c));

   rtc_bcd_field #(.W(8), .FIRST_V(0), .RST_V(0)) u_year (
      .clk(clk), .rst_n(rst_n), .load(w_year), .load_val(wr_data),
      .step(mon_c), .last_val(8'h99), .q(year_q), .carry(year_c));

   // control, validity and century bits
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stop_q <= 1'b0;
         vl_q   <= 1'b1;
         cent_q <= 1'b0;
      end else begin
         if (w_ctrl) stop_q <= wr_data[STOP_POS];
         if (pwr_fail)   vl_q <= 1'b1;
         else if (w_sec) vl_q <= wr_data[FLAG_POS];
         if (w_mon)       cent_q <= wr_data[FLAG_POS];
         else if (year_c) cent_q <= ~cent_q;
      end
   end

   // weekday wrap carry is not consumed further
   logic unused_ok;
   assign unused_ok = wday_c;

   always_comb begin
      rd_data = '0;
      if      (hit(rd_addr, RA_CTRL)) rd_data[STOP_POS] = stop_q;
      else if (hit(rd_addr, RA_SEC))  rd_data = {vl_q, sec_q};
      else if (hit(rd_addr, RA_MIN))  rd_data = {1'b0, min_q};
      else if (hit(rd_addr, RA_HOUR)) rd_data = {2'b0, hour_q};
      else if (hit(rd_addr, RA_DAY))  rd_data = {2'b0, day_q};
      else if (hit(rd_addr, RA_WDAY)) rd_data = {5'b0, wday_q};
      else if (hit(rd_addr, RA_MON))  rd_data = {cent_q, 2'b0, mon_q};
      else if (hit(rd_addr, RA_YEAR)) rd_data = year_q;
   end
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk #(
   parameter int unsigned ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pwr_fail,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [7:0]        wr_data,
   input logic              sec_tick,
   input logic              stop_q,
   input logic              vl_q,
   input logic              cent_q,
   input logic [6:0]        sec_q,
   input logic [6:0]        min_q,
   input logic [5:0]        hour_q,
   input logic [5:0]        day_q,
   input logic [4:0]        mon_q,
   input logic [7:0]        year_q
);
   // R9
   freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_q && !wr_en) |=> ($stable(sec_q) && $stable(min_q) && $stable(hour_q) && $stable(day_q)));

   // R9
   stopped_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_q |-> !sec_tick);

   // R11
   vl_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_fail |=> vl_q);

   // R11
   vl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(vl_q) |-> $past(wr_en && wr_addr == ADDR_W'(2) && !wr_data[7] && !pwr_fail));

   // R4
   sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_tick && sec_q == 7'h59 && !wr_en) |=> (sec_q == 7'h00 && min_q != $past(min_q)));

   // R4
   hour_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_tick && sec_q == 7'h59 && min_q == 7'h59 && hour_q == 6'h23 && !wr_en) |=> (hour_q == 6'h00));

   // R3
   sec_bcd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_q[3:0] <= 4'd9) && (sec_q <= 7'h59));

   // R8
   century_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(wr_en) && !$stable(cent_q)) |-> (mon_q == 5'h01 && year_q == 8'h00));
endmodule

bind rtc_calendar_core rtc_calendar_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail), .wr_en(wr_en),
   .wr_addr(wr_addr), .wr_data(wr_data), .sec_tick(sec_tick),
   .stop_q(stop_q), .vl_q(vl_q), .cent_q(cent_q), .sec_q(sec_q),
   .min_q(min_q), .hour_q(hour_q), .day_q(day_q), .mon_q(mon_q),
   .year_q(year_q)
);

// File: tb/tb_rtc_calendar_core.sv
module tb_rtc_calendar_core;
   localparam int DIV = 4;

   logic       clk = 0;
   logic       rst_n = 0;
   logic       ref_en = 0;
   logic       pwr_fail = 0;
   logic       wr_en = 0;
   logic [3:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [3:0] rd_addr = '0;
   logic [7:0] rd_data;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   bit busy = 0;

   logic [3:0] q_addr[$];
   logic [7:0] q_exp[$];
   string      q_req[$];

   always #5 clk = ~clk;

   rtc_calendar_core #(.PRESCALE_DIV(DIV), .ADDR_W(4)) dut (
      .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .pwr_fail(pwr_fail),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data)
   );

   // monitor: pops expected items and compares them against the read port
   initial begin
      forever begin
         @(negedge clk);
         if (q_addr.size() > 0) begin
            logic [3:0] a;
            logic [7:0] e;
            string r;
            busy = 1;
            a = q_addr.pop_front();
            e = q_exp.pop_front();
            r = q_req.pop_front();
            rd_addr = a;
            #1;
            checks++;
            if (rd_data !== e) begin
               errors++;
               $display("FAIL %s addr=%0h actual=%02h expected=%02h", r, a, rd_data, e);
            end
            busy = 0;
         end
      end
   end

   task automatic expect_rd(input logic [3:0] a, input logic [7:0] e, input string r);
      q_addr.push_back(a);
      q_exp.push_back(e);
      q_req.push_back(r);
   endtask

   task automatic drain();
      wait (q_addr.size() == 0 && !busy);
      @(negedge clk);
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 0;
   endtask

   task automatic pulses(input int n);
      @(negedge clk);
      ref_en = 1;
      repeat (n) @(negedge clk);
      ref_en = 0;
   endtask

   task automatic set_time(input logic [7:0] s, input logic [7:0] mi, input logic [7:0] h,
                           input logic [7:0] d, input logic [7:0] wd, input logic [7:0] mo,
                           input logic [7:0] y);
      wr(4'h0, 8'h20);
      wr(4'h2, s); wr(4'h3, mi); wr(4'h4, h); wr(4'h5, d);
      wr(4'h6, wd); wr(4'h7, mo); wr(4'h8, y);
      wr(4'h0, 8'h00);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R1 reset state
      expect_rd(4'h2, 8'h80, "R1 sec");
      expect_rd(4'h3, 8'h00, "R1 min");
      expect_rd(4'h4, 8'h00, "R1 hour");
      expect_rd(4'h5, 8'h01, "R1 day");
      expect_rd(4'h6, 8'h00, "R1 wday");
      expect_rd(4'h7, 8'h01, "R1 month");
      expect_rd(4'h8, 8'h00, "R1 year");
      expect_rd(4'h0, 8'h00, "R1 ctrl");
      drain();

      // R11 validity flag
      wr(4'h2, 8'h00);
      expect_rd(4'h2, 8'h00, "R11 flag cleared by write");
      drain();
      @(negedge clk); pwr_fail = 1; @(negedge clk); pwr_fail = 0;
      expect_rd(4'h2, 8'h80, "R11 flag set by pwr_fail");
      drain();
      @(negedge clk); pwr_fail = 1; wr_en = 1; wr_addr = 4'h2; wr_data = 8'h00;
      @(negedge clk); pwr_fail = 0; wr_en = 0;
      expect_rd(4'h2, 8'h80, "R11 pwr_fail beats write");
      drain();
      wr(4'h2, 8'h00);

      // R2 register map and masking
      wr(4'h0, 8'hFF);
      expect_rd(4'h0, 8'h20, "R2 ctrl only stop bit");
      drain();
      wr(4'h4, 8'hD5);
      wr(4'h6, 8'hFE);
      expect_rd(4'h4, 8'h15, "R2 hour mask");
      expect_rd(4'h6, 8'h06, "R2 wday mask");
      expect_rd(4'h1, 8'h00, "R2 unmapped");
      drain();

      // R9 stopped: no advance
      pulses(12);
      expect_rd(4'h2, 8'h00, "R9 sec frozen");
      expect_rd(4'h4, 8'h15, "R9 hour frozen");
      drain();

      // R3 R4 R5 R6 R8 full rollover
      set_time(8'h58, 8'h59, 8'h23, 8'h31, 8'h06, 8'h12, 8'h99);
      pulses(DIV - 1);
      expect_rd(4'h2, 8'h58, "R3 no step before period");
      drain();
      pulses(1);
      expect_rd(4'h2, 8'h59, "R3 step at period");
      drain();
      pulses(DIV);
      expect_rd(4'h2, 8'h00, "R4 sec wrap");
      expect_rd(4'h3, 8'h00, "R4 min wrap");
      expect_rd(4'h4, 8'h00, "R4 hour wrap");
      expect_rd(4'h5, 8'h01, "R6 day wrap after 31 in Dec");
      expect_rd(4'h6, 8'h00, "R5 wday 6 to 0");
      expect_rd(4'h7, 8'h81, "R8 month wrap and century set");
      expect_rd(4'h8, 8'h00, "R8 year wrap");
      drain();

      // R8 century toggles back
      set_time(8'h59, 8'h59, 8'h23, 8'h31, 8'h03, 8'h92, 8'h99);
      pulses(DIV);
      expect_rd(4'h7, 8'h01, "R8 century cleared on wrap");
      expect_rd(4'h6, 8'h04, "R5 wday 3 to 4");
      drain();

      // R4 BCD digit carry in minutes
      set_time(8'h59, 8'h09, 8'h10, 8'h05, 8'h01, 8'h05, 8'h20);
      pulses(DIV);
      expect_rd(4'h3, 8'h10, "R4 minute BCD digit carry");
      expect_rd(4'h4, 8'h10, "R4 hour untouched");
      drain();

      // R6 30-day and 31-day months
      set_time(8'h59, 8'h59, 8'h23, 8'h30, 8'h01, 8'h04, 8'h20);
      pulses(DIV);
      expect_rd(4'h5, 8'h01, "R6 April day 30 wraps");
      expect_rd(4'h7, 8'h05, "R6 month carry");
      drain();
      set_time(8'h59, 8'h59, 8'h23, 8'h30, 8'h01, 8'h05, 8'h20);
      pulses(DIV);
      expect_rd(4'h5, 8'h31, "R6 May day 30 to 31");
      drain();

      // R7 February
      set_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h01, 8'h02, 8'h24);
      pulses(DIV);
      expect_rd(4'h5, 8'h29, "R7 leap Feb 28 to 29");
      expect_rd(4'h7, 8'h02, "R7 leap stays Feb");
      drain();
      set_time(8'h59, 8'h59, 8'h23, 8'h29, 8'h01, 8'h02, 8'h12);
      pulses(DIV);
      expect_rd(4'h5, 8'h01, "R7 leap Feb 29 wraps");
      expect_rd(4'h7, 8'h03, "R7 leap to March");
      drain();
      set_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h01, 8'h02, 8'h23);
      pulses(DIV);
      expect_rd(4'h5, 8'h01, "R7 common Feb 28 wraps");
      expect_rd(4'h7, 8'h03, "R7 common to March");
      drain();

      // R10 prescaler cleared by write while stopped
      set_time(8'h05, 8'h00, 8'h00, 8'h01, 8'h00, 8'h01, 8'h00);
      pulses(2);
      wr(4'h0, 8'h20);
      wr(4'h2, 8'h10);
      wr(4'h0, 8'h00);
      pulses(DIV - 1);
      expect_rd(4'h2, 8'h10, "R10 no early step after release");
      drain();
      pulses(1);
      expect_rd(4'h2, 8'h11, "R10 step after full period");
      drain();

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule